// File: doc/BRIEF.md
# Core Power-State Sequencer

This block follows the power state of one processor core and decides which internal clock domains keep running. There are four states: running, halted after a HALT instruction, stop-clock granted, and sleeping. The block moves between them on a HALT-retired strobe, a stop-clock request, a sleep request and five wake events (SMI, INIT, BINIT, NMI, INTR). It marks two transitions with one-cycle strobes, one for the HALT special bus cycle and one for the Stop Grant special bus cycle. Other logic in the core uses these strobes to launch the actual bus cycles.

A cache flush requested while halted is tracked with a busy/acknowledge pair. The flush itself is done elsewhere, and the core stays halted when it finishes. Wake events that arrive while the stop-clock request is high, or while a flush is running, are held until they can be taken. A configuration word write sets the clock-stop policy. Bit 26 of that word chooses between stopping every gated domain and keeping the snoop and timer domains alive.

Top module: `pwr_state_ctrl`

## Requirements
- R1: During and after reset, the state is Normal (encoding 0), both bus-cycle strobes are 0, flush_busy is 0, all three clock enables are 1 and snoop_ack_en is 1. Reset wins over every other input.
- R2: A halt_done pulse in Normal moves the state to Auto HALT (encoding 1) at the next clock edge. halt_cycle is 1 for exactly that one cycle.
- R3: In Auto HALT with no flush running and stpclk_req low, any one of SMI, INIT, BINIT, NMI or INTR moves the state to Normal at the next edge.
- R4: A flush_req in Auto HALT raises flush_busy from the next edge until the edge that samples flush_ack, and the state stays Auto HALT throughout. Wake events seen during the flush are taken one edge after it ends.
- R5: stpclk_req high in Normal or Auto HALT moves the state to Stop Grant (encoding 2). stop_grant_cycle is 1 for exactly that one cycle. In Normal, stpclk_req takes precedence over halt_done in the same cycle.
- R6: When stpclk_req drops, Stop Grant returns to the state it was entered from. halt_cycle stays 0 on a return to Auto HALT.
- R7: Wake events seen in Stop Grant do not change the state while stpclk_req is high. After the return to Auto HALT they move the state to Normal at the next edge.
- R8: Sleep (encoding 3) is entered only from Stop Grant with sleep_req high. sleep_req has no effect in Normal or Auto HALT. Dropping sleep_req returns the state to Stop Grant.
- R9: snoop_ack_en is 0 exactly while the state is Sleep.
- R10: core_clk_en is 1 only in Normal. snoop_clk_en and timer_clk_en are 1 in Normal and Auto HALT. With the stop-all bit clear, Stop Grant keeps snoop and timer running and Sleep keeps only the timer running. With the bit set, both Stop Grant and Sleep clear all three enables.
- R11: When the wake from Auto HALT included SMI, a later smi_return in Normal sends the state back to Auto HALT with halt_cycle 0. After any other wake, smi_return leaves the state in Normal.
- R12: The stop-all bit is bit 26 of cfg_wdata and is loaded on a cfg_we cycle. It resets to 0. No other bit of cfg_wdata has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_done | input | 1 | HALT instruction retired strobe |
| stpclk_req | input | 1 | Stop-clock request level |
| sleep_req | input | 1 | Sleep request level |
| smi_evt | input | 1 | System management interrupt event |
| init_evt | input | 1 | INIT event |
| binit_evt | input | 1 | Bus initialisation event |
| nmi_evt | input | 1 | Non-maskable interrupt event |
| intr_evt | input | 1 | Maskable interrupt event |
| smi_return | input | 1 | SMI handler return strobe |
| flush_req | input | 1 | Cache flush request |
| flush_ack | input | 1 | Cache flush finished |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word (bit 26 = stop all) |
| state | output | 2 | Current state: 0 Normal, 1 Auto HALT, 2 Stop Grant, 3 Sleep |
| halt_cycle | output | 1 | HALT special bus cycle strobe |
| stop_grant_cycle | output | 1 | Stop Grant special bus cycle strobe |
| flush_busy | output | 1 | Flush in progress |
| snoop_ack_en | output | 1 | Snoop acknowledge allowed |
| core_clk_en | output | 1 | Core clock domain enable |
| snoop_clk_en | output | 1 | Snoop/cache clock domain enable |
| timer_clk_en | output | 1 | Timer/interrupt clock domain enable |

## Verification
A wrong origin flag or resume flag stays hidden until the exit it controls. It shows up as a return to the wrong state, which is visible on `state` one edge after stpclk_req drops or after smi_return. A lost pending event shows up as the core staying in Auto HALT one edge after the flush ends or after Stop Grant is left. Because the clock enables and snoop_ack_en are decoded directly from state, a wrong state or a wrong stop-all bit is visible on them in the same cycle. The checks sweep every wake source, every configuration bit position and both clock-stop policies.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PS_NORMAL = 2'd0,
    PS_HALT   = 2'd1,
    PS_STPGNT = 2'd2,
    PS_SLEEP  = 2'd3
  } pstate_e;

  localparam int NUM_WAKE = 5;
  localparam int WAKE_SMI = 0;

  // Clock enables returned as {timer, snoop, core}
  function automatic logic [2:0] gate_for(pstate_e s, logic stop_all);
    logic [2:0] g;
    case (s)
      PS_NORMAL: g = 3'b111;
      PS_HALT:   g = 3'b110;
      PS_STPGNT: g = stop_all ? 3'b000 : 3'b110;
      default:   g = stop_all ? 3'b000 : 3'b100;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pwr_wake_latch.sv
module pwr_wake_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_in,
  input  logic         consume,
  output logic [N-1:0] wake_vec
);

  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q[i] <= 1'b0;
      else if (consume) pend_q[i] <= 1'b0;
      else              pend_q[i] <= pend_q[i] | evt_in[i];
    end
  end

  assign wake_vec = pend_q | evt_in;

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !consume |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
#(
  parameter int N = NUM_WAKE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halt_done,
  input  logic         stpclk_req,
  input  logic         sleep_req,
  input  logic [N-1:0] wake_vec,
  input  logic         smi_return,
  input  logic         flush_req,
  input  logic         flush_ack,
  output pstate_e      st_o,
  output logic         halt_stb_o,
  output logic         sg_stb_o,
  output logic         flush_busy_o,
  output logic         consume_o
);

  pstate_e st_q, st_d;
  logic from_halt_q, from_halt_d;
  logic resume_q, resume_d;
  logic flush_q, flush_d;
  logic h_stb_d, s_stb_d, h_stb_q, s_stb_q;
  logic wake_take;

  always_comb begin
    st_d = st_q;
    from_halt_d = from_halt_q;
    resume_d = resume_q;
    flush_d = flush_q;
    h_stb_d = 1'b0;
    s_stb_d = 1'b0;
    wake_take = 1'b0;
    case (st_q)
      PS_NORMAL: begin
        if (stpclk_req) begin
          st_d = PS_STPGNT;
          from_halt_d = 1'b0;
          s_stb_d = 1'b1;
        end else if (smi_return) begin
          resume_d = 1'b0;
          if (resume_q) st_d = PS_HALT;
        end else if (halt_done) begin
          st_d = PS_HALT;
          h_stb_d = 1'b1;
        end
      end
      PS_HALT: begin
        if (flush_q) begin
          if (flush_ack) flush_d = 1'b0;
        end else if (stpclk_req) begin
          st_d = PS_STPGNT;
          from_halt_d = 1'b1;
          s_stb_d = 1'b1;
        end else if (|wake_vec) begin
          st_d = PS_NORMAL;
          wake_take = 1'b1;
          resume_d = wake_vec[WAKE_SMI];
        end else if (flush_req) begin
          flush_d = 1'b1;
        end
      end
      PS_STPGNT: begin
        if (!stpclk_req)    st_d = from_halt_q ? PS_HALT : PS_NORMAL;
        else if (sleep_req) st_d = PS_SLEEP;
      end
      default: begin
        if (!sleep_req) st_d = PS_STPGNT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_NORMAL;
      from_halt_q <= 1'b0;
      resume_q <= 1'b0;
      flush_q <= 1'b0;
      h_stb_q <= 1'b0;
      s_stb_q <= 1'b0;
    end else begin
      st_q <= st_d;
      from_halt_q <= from_halt_d;
      resume_q <= resume_d;
      flush_q <= flush_d;
      h_stb_q <= h_stb_d;
      s_stb_q <= s_stb_d;
    end
  end

  assign st_o = st_q;
  assign halt_stb_o = h_stb_q;
  assign sg_stb_o = s_stb_q;
  assign flush_busy_o = flush_q;
  assign consume_o = (st_q == PS_NORMAL) || wake_take;

  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_stb_o |-> (st_q == PS_HALT && $past(st_q) == PS_NORMAL));
  // R5
  sg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sg_stb_o |-> (st_q == PS_STPGNT && $past(st_q) != PS_STPGNT));
  // R8
  sleep_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SLEEP) |-> ($past(st_q) == PS_STPGNT || $past(st_q) == PS_SLEEP));
  // R4
  flush_in_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> (st_q == PS_HALT));
  // R3
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_take |=> (st_q == PS_NORMAL));

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int STOP_BIT = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  pstate_e          st,
  output logic             core_en,
  output logic             snoop_en,
  output logic             timer_en,
  output logic             snoop_ack_en
);

  logic stop_all_q;
  logic unused_cfg_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stop_all_q <= 1'b0;
    else if (cfg_we) stop_all_q <= cfg_wdata[STOP_BIT];
  end

  assign unused_cfg_bits = ^cfg_wdata;
  assign {timer_en, snoop_en, core_en} = gate_for(st, stop_all_q);
  assign snoop_ack_en = (st != PS_SLEEP);

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(stop_all_q));
  // R10
  core_only_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> (st == PS_NORMAL));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int STOP_BIT = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_done,
  input  logic             stpclk_req,
  input  logic             sleep_req,
  input  logic             smi_evt,
  input  logic             init_evt,
  input  logic             binit_evt,
  input  logic             nmi_evt,
  input  logic             intr_evt,
  input  logic             smi_return,
  input  logic             flush_req,
  input  logic             flush_ack,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [1:0]       state,
  output logic             halt_cycle,
  output logic             stop_grant_cycle,
  output logic             flush_busy,
  output logic             snoop_ack_en,
  output logic             core_clk_en,
  output logic             snoop_clk_en,
  output logic             timer_clk_en
);

  logic [NUM_WAKE-1:0] evt_vec, wake_vec;
  logic consume;
  pstate_e st;

  assign evt_vec = {intr_evt, nmi_evt, init_evt, binit_evt, smi_evt};

  pwr_wake_latch #(.N(NUM_WAKE)) u_wake (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_vec), .consume(consume), .wake_vec(wake_vec)
  );

  pwr_fsm #(.N(NUM_WAKE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .halt_done(halt_done), .stpclk_req(stpclk_req),
    .sleep_req(sleep_req), .wake_vec(wake_vec), .smi_return(smi_return),
    .flush_req(flush_req), .flush_ack(flush_ack), .st_o(st),
    .halt_stb_o(halt_cycle), .sg_stb_o(stop_grant_cycle),
    .flush_busy_o(flush_busy), .consume_o(consume)
  );

  pwr_clk_gate #(.CFG_W(CFG_W), .STOP_BIT(STOP_BIT)) u_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .st(st),
    .core_en(core_clk_en), .snoop_en(snoop_clk_en), .timer_en(timer_clk_en),
    .snoop_ack_en(snoop_ack_en)
  );

  assign state = st;

endmodule

// File: tb/pwr_state_ctrl_tb.sv
module pwr_state_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_done = 0, stpclk_req = 0, sleep_req = 0;
  logic smi_evt = 0, init_evt = 0, binit_evt = 0, nmi_evt = 0, intr_evt = 0;
  logic smi_return = 0, flush_req = 0, flush_ack = 0, cfg_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0] state;
  logic halt_cycle, stop_grant_cycle, flush_busy, snoop_ack_en;
  logic core_clk_en, snoop_clk_en, timer_clk_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic full_mode = 0;

  always #2 clk = ~clk;

  pwr_state_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .halt_done(halt_done), .stpclk_req(stpclk_req),
    .sleep_req(sleep_req), .smi_evt(smi_evt), .init_evt(init_evt),
    .binit_evt(binit_evt), .nmi_evt(nmi_evt), .intr_evt(intr_evt),
    .smi_return(smi_return), .flush_req(flush_req), .flush_ack(flush_ack),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .state(state), .halt_cycle(halt_cycle),
    .stop_grant_cycle(stop_grant_cycle), .flush_busy(flush_busy),
    .snoop_ack_en(snoop_ack_en), .core_clk_en(core_clk_en),
    .snoop_clk_en(snoop_clk_en), .timer_clk_en(timer_clk_en)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Enables expected as {timer, snoop, core}, derived from the requirement wording
  function automatic int exp_gate(int s, logic full);
    int core, snoop, timer;
    core  = (s == 0) ? 1 : 0;
    snoop = (s < 2 || (s == 2 && !full)) ? 1 : 0;
    timer = (s < 2 || !full) ? 1 : 0;
    return timer * 4 + snoop * 2 + core;
  endfunction

  task automatic chk_gate(string req);
    chk(req, {timer_clk_en, snoop_clk_en, core_clk_en}, exp_gate(state, full_mode));
    chk("R9", snoop_ack_en, (state == 3) ? 0 : 1);
  endtask

  task automatic set_evt(int k, logic v);
    case (k)
      0: smi_evt = v;
      1: binit_evt = v;
      2: init_evt = v;
      3: nmi_evt = v;
      default: intr_evt = v;
    endcase
  endtask

  task automatic enter_halt();
    halt_done = 1; tick(); halt_done = 0;
    chk("R2 state", state, 1);
    chk("R2 pulse", halt_cycle, 1);
    tick();
    chk("R2 pulse width", halt_cycle, 0);
    chk_gate("R10 halt");
  endtask

  initial begin
    #1;
    chk("R1 state", state, 0);
    chk("R1 enables", {timer_clk_en, snoop_clk_en, core_clk_en}, 7);
    tick(); tick();
    chk("R1 strobes", {halt_cycle, stop_grant_cycle, flush_busy}, 0);
    chk("R1 snoop ack", snoop_ack_en, 1);
    rst_n = 1;
    tick();
    chk("R1 state after release", state, 0);

    // R12: reset value of the stop-all bit gives partial gating in Stop Grant
    stpclk_req = 1; tick();
    chk("R5 state", state, 2);
    chk("R5 pulse", stop_grant_cycle, 1);
    chk_gate("R12 reset value");
    stpclk_req = 0; tick();
    chk("R6 back to normal", state, 0);

    // R12 sweep of every configuration bit position
    for (int b = 0; b < 32; b++) begin
      cfg_wdata = 32'd1 << b; cfg_we = 1; tick(); cfg_we = 0; cfg_wdata = '0;
      full_mode = (b == 26);
      stpclk_req = 1; tick();
      chk("R12 sweep state", state, 2);
      chk_gate("R12 bit sweep");
      tick();
      chk("R5 pulse width", stop_grant_cycle, 0);
      stpclk_req = 0; tick();
      chk("R6 return", state, 0);
      chk("R6 no halt cycle", halt_cycle, 0);
    end
    cfg_we = 1; tick(); cfg_we = 0; full_mode = 0;

    // R3 and R11 over every wake source
    for (int k = 0; k < 5; k++) begin
      enter_halt();
      set_evt(k, 1); tick(); set_evt(k, 0);
      chk("R3 wake", state, 0);
      smi_return = 1; tick(); smi_return = 0;
      chk("R11 resume", state, (k == 0) ? 1 : 0);
      chk("R11 no halt cycle", halt_cycle, 0);
      if (k == 0) begin
        intr_evt = 1; tick(); intr_evt = 0;
        chk("R3 wake after resume", state, 0);
      end
    end

    // R5 precedence over halt_done
    stpclk_req = 1; halt_done = 1; tick(); halt_done = 0;
    chk("R5 precedence", state, 2);
    stpclk_req = 0; tick();
    chk("R6 return", state, 0);

    // R4 flush while halted with an event arriving mid-flush
    enter_halt();
    flush_req = 1; tick(); flush_req = 0;
    chk("R4 busy", flush_busy, 1);
    chk("R4 state", state, 1);
    intr_evt = 1; tick(); intr_evt = 0;
    chk("R4 held", state, 1);
    tick();
    chk("R4 still busy", flush_busy, 1);
    flush_ack = 1; tick(); flush_ack = 0;
    chk("R4 done", flush_busy, 0);
    chk("R4 stays halted", state, 1);
    tick();
    chk("R4 pending taken", state, 0);

    // R7 events during Stop Grant entered from Auto HALT
    enter_halt();
    stpclk_req = 1; tick();
    chk("R5 from halt", state, 2);
    chk("R5 pulse", stop_grant_cycle, 1);
    nmi_evt = 1; tick(); nmi_evt = 0;
    chk("R7 held in stop grant", state, 2);
    tick();
    chk("R7 still held", state, 2);
    stpclk_req = 0; tick();
    chk("R6 back to halt", state, 1);
    chk("R6 no halt cycle", halt_cycle, 0);
    tick();
    chk("R7 pending taken", state, 0);

    // R8, R9, R10 with both clock-stop policies
    for (int f = 0; f < 2; f++) begin
      cfg_wdata = (f == 1) ? (32'd1 << 26) : 32'd0; cfg_we = 1; tick(); cfg_we = 0;
      full_mode = (f == 1);
      sleep_req = 1; tick();
      chk("R8 ignored in normal", state, 0);
      chk_gate("R10 normal");
      sleep_req = 0;
      enter_halt();
      sleep_req = 1; tick();
      chk("R8 ignored in halt", state, 1);
      sleep_req = 0;
      stpclk_req = 1; tick();
      chk_gate("R10 stop grant");
      sleep_req = 1; tick();
      chk("R8 sleep", state, 3);
      chk_gate("R10 sleep");
      sleep_req = 0; tick();
      chk("R8 wake to stop grant", state, 2);
      chk("R9 ack back", snoop_ack_en, 1);
      stpclk_req = 0; tick();
      chk("R6 back to halt", state, 1);
      intr_evt = 1; tick(); intr_evt = 0;
      chk("R3 leave halt", state, 0);
    end

    // R1 reset wins from Sleep
    stpclk_req = 1; tick(); sleep_req = 1; tick();
    chk("R8 sleep again", state, 3);
    rst_n = 0; #1;
    chk("R1 async reset", state, 0);
    chk_gate("R1 enables after reset");
    stpclk_req = 0; sleep_req = 0;
    tick(); rst_n = 1; tick();
    chk("R1 state after reset", state, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule